// File: doc/BRIEF.md
# Cell Injection Start/Stop Controller

This block decides when the cells waiting in a transmit queue of buffer descriptors may be pushed into a switching fabric. It watches a queue-occupied flag, a go strobe from the processor, a set of NACK lines and a per-cell completion signal from the byte sender. From these it issues a one-clock start request for each cell and shows whether injection is currently armed.

Arming is sticky. Once the processor has strobed go, cells leave back to back for as long as the queue holds entries. If the queue runs dry, the controller waits and resumes by itself when a new entry shows up. Only a NACK, from the fabric or from the far port, disarms it. After a NACK, or after reset, a fresh go strobe is needed. A cell that is already in flight always runs to completion. This holds when a go or a NACK arrives during it.

Top module: `inj_start_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `injArmed` is 0 and `startCell` is 0.
- R2: With the controller disarmed, no `startCell` pulse is issued, however long `queueNotEmpty` stays 1.
- R3: A `goStrobe` in a cycle with every `nackIn` bit at 0 makes `injArmed` 1 from the next cycle. If `queueNotEmpty` is 1 and no cell is in flight, `startCell` is 1 in that next cycle.
- R4: `startCell` is 1 for exactly one clock per cell. No further pulse comes until `cellDone` has been seen. If the controller is still armed and the queue is occupied when `cellDone` arrives, the next pulse comes in the cycle right after `cellDone`.
- R5: While `queueNotEmpty` is 0, no `startCell` is issued and `injArmed` is unchanged. When an entry appears, a start follows on the next cycle with no new go strobe.
- R6: Any bit of `nackIn` at 1 makes `injArmed` 0 from the next cycle. No further cell starts until a later `goStrobe`.
- R7: A `goStrobe` during a cell in flight sets `injArmed` without issuing an extra start. The cell in flight keeps its slot until `cellDone`.
- R8: A NACK during a cell in flight lets that cell finish. No new start follows its `cellDone`.
- R9: When `goStrobe` and a NACK bit are both 1 in the same cycle, the NACK wins and `injArmed` becomes 0.
- R10: `cellDone` while no cell is in flight has no effect on `startCell` or `injArmed`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| queueNotEmpty | input | 1 | Transmit queue holds at least one descriptor |
| goStrobe | input | 1 | Processor go pulse; arms injection |
| nackIn | input | NACK_SRCS | NACK lines (fabric, destination port); any bit disarms |
| cellDone | input | 1 | Byte sender has finished the current cell |
| startCell | output | 1 | One-clock request to send the cell at the head of the queue |
| injArmed | output | 1 | Injection is armed (readable status) |

## Verification
The arming path is exercised several ways. A queue that stays occupied with no go strobe separates a missing arm condition from a queue-only trigger. A go pulse on an occupied queue, followed by prompt and delayed `cellDone`, shows both the single-clock start pulse and the back-to-back restart. Draining the queue and then refilling it, without a new go, separates the sticky enable from one that needs re-arming. NACKs on each source line, a go strobe inside a cell, and a go coinciding with a NACK show when arming changes, when a cell in flight is protected, and which event has priority. A reference model in the bench is compared with both outputs on every clock.

// File: rtl/inj_start_pkg.sv
package inj_start_pkg;

  // Strobes from the arming control to the cell sequencing datapath.
  typedef struct packed {
    logic launch;   // issue a start request at the next edge
    logic armed;    // current armed state
  } injStrobe_t;

endpackage

// File: rtl/inj_arm_ctrl.sv
module inj_arm_ctrl
  import inj_start_pkg::*;
#(
  parameter int NACK_SRCS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 queueNotEmpty,
  input  logic                 goStrobe,
  input  logic [NACK_SRCS-1:0] nackIn,
  input  logic                 slotFree,
  output injStrobe_t           strb
);

  logic armed;
  logic armedNext;
  logic nackAny;

  assign nackAny = |nackIn;

  // A NACK takes priority over a coincident go strobe.
  always_comb begin
    armedNext = armed;
    if (nackAny)       armedNext = 1'b0;
    else if (goStrobe) armedNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= armedNext;
  end

  assign strb.launch = armedNext & queueNotEmpty & slotFree;
  assign strb.armed  = armed;

endmodule

// File: rtl/inj_cell_seq.sv
module inj_cell_seq
  import inj_start_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  injStrobe_t strb,
  input  logic       cellDone,
  output logic       slotFree,
  output logic       startCell,
  output logic       injArmed
);

  logic inFlight;
  logic startReg;

  // The slot opens when nothing is in flight or the current cell just retired.
  assign slotFree = ~inFlight | cellDone;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startReg <= 1'b0;
      inFlight <= 1'b0;
    end else begin
      startReg <= strb.launch;
      inFlight <= strb.launch | (inFlight & ~cellDone);
    end
  end

  assign startCell = startReg;
  assign injArmed  = strb.armed;

endmodule

// File: rtl/inj_start_ctrl.sv
module inj_start_ctrl
  import inj_start_pkg::*;
#(
  parameter int NACK_SRCS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 queueNotEmpty,
  input  logic                 goStrobe,
  input  logic [NACK_SRCS-1:0] nackIn,
  input  logic                 cellDone,
  output logic                 startCell,
  output logic                 injArmed
);

  injStrobe_t strb;
  logic       slotFree;

  inj_arm_ctrl #(.NACK_SRCS(NACK_SRCS)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .queueNotEmpty (queueNotEmpty),
    .goStrobe      (goStrobe),
    .nackIn        (nackIn),
    .slotFree      (slotFree),
    .strb          (strb)
  );

  inj_cell_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .cellDone  (cellDone),
    .slotFree  (slotFree),
    .startCell (startCell),
    .injArmed  (injArmed)
  );

endmodule

// File: rtl/inj_start_ctrl_chk.sv
module inj_start_ctrl_chk #(
  parameter int NACK_SRCS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 queueNotEmpty,
  input logic                 goStrobe,
  input logic [NACK_SRCS-1:0] nackIn,
  input logic                 cellDone,
  input logic                 startCell,
  input logic                 injArmed
);

  logic holdBusy, busyNow, prevBusy, prevDone, prevQne;

  assign busyNow = startCell | holdBusy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdBusy <= 1'b0;
      prevBusy <= 1'b0;
      prevDone <= 1'b0;
      prevQne  <= 1'b0;
    end else begin
      holdBusy <= busyNow & ~cellDone;
      prevBusy <= busyNow;
      prevDone <= cellDone;
      prevQne  <= queueNotEmpty;
    end
  end

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startCell && !cellDone) |=> !startCell);

  // R4
  start_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startCell |-> (!prevBusy || prevDone));

  // R6
  nack_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|nackIn) |=> !injArmed);

  // R3
  go_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (goStrobe && !(|nackIn)) |=> injArmed);

  // R2
  start_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startCell |-> injArmed);

  // R5
  start_needs_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startCell |-> prevQne);

endmodule

bind inj_start_ctrl inj_start_ctrl_chk #(.NACK_SRCS(NACK_SRCS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .queueNotEmpty (queueNotEmpty),
  .goStrobe      (goStrobe),
  .nackIn        (nackIn),
  .cellDone      (cellDone),
  .startCell     (startCell),
  .injArmed      (injArmed)
);

// File: tb/inj_start_ctrl_bench.sv
`timescale 1ns/1ps
module inj_start_ctrl_bench;

  localparam int NS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          queueNotEmpty = 1'b0;
  logic          goStrobe = 1'b0;
  logic [NS-1:0] nackIn = '0;
  logic          cellDone = 1'b0;
  logic          startCell, injArmed;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural reference state
  int mArmed = 0, mBusy = 0, mStart = 0;

  always #2 clk = ~clk;

  inj_start_ctrl #(.NACK_SRCS(NS)) u_inj_start_ctrl (
    .clk(clk), .rst_n(rst_n), .queueNotEmpty(queueNotEmpty),
    .goStrobe(goStrobe), .nackIn(nackIn), .cellDone(cellDone),
    .startCell(startCell), .injArmed(injArmed)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mArmed = 0; mBusy = 0; mStart = 0;
    end else begin
      int na;
      int free;
      na = mArmed;
      if (nackIn != 0) na = 0;
      else if (goStrobe) na = 1;
      free = (mBusy == 0) || cellDone;
      mStart = (na != 0) && queueNotEmpty && free;
      if (mStart != 0) mBusy = 1;
      else if (cellDone) mBusy = 0;
      mArmed = na;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(curReq, "startCell vs model", int'(startCell), mStart);
      chk(curReq, "injArmed vs model", int'(injArmed), mArmed);
    end
  end

  // one clock with the given pulses, then sample after the edge at negedge
  task automatic cyc(logic g, logic [NS-1:0] n, logic d);
    goStrobe = g; nackIn = n; cellDone = d;
    @(posedge clk);
    @(negedge clk);
    goStrobe = 1'b0; nackIn = '0; cellDone = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) begin
      chk("R1", "armed in reset", int'(injArmed), 0);
      chk("R1", "start in reset", int'(startCell), 0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    cyc(0, '0, 0);
    chk("R1", "armed after reset", int'(injArmed), 0);
    chk("R1", "start after reset", int'(startCell), 0);

    // R2: occupied queue, never armed
    curReq = "R2";
    queueNotEmpty = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cyc(0, '0, 0);
      chk("R2", "no start disarmed", int'(startCell), 0);
    end

    // R3: go arms and launches
    curReq = "R3";
    cyc(1, '0, 0);
    chk("R3", "armed after go", int'(injArmed), 1);
    chk("R3", "start after go", int'(startCell), 1);

    // R4: single pulse, wait for done, back to back
    curReq = "R4";
    for (int i = 0; i < 3; i++) begin
      cyc(0, '0, 0);
      chk("R4", "no start in flight", int'(startCell), 0);
    end
    cyc(0, '0, 1);
    chk("R4", "back-to-back start", int'(startCell), 1);
    cyc(0, '0, 1);
    chk("R4", "prompt done restart", int'(startCell), 1);

    // R5: queue drains, then refills without go
    curReq = "R5";
    queueNotEmpty = 1'b0;
    cyc(0, '0, 1);
    chk("R5", "no start empty", int'(startCell), 0);
    chk("R5", "stays armed empty", int'(injArmed), 1);
    // R10: done while idle
    curReq = "R10";
    cyc(0, '0, 1);
    cyc(0, '0, 1);
    chk("R10", "idle done start", int'(startCell), 0);
    chk("R10", "idle done armed", int'(injArmed), 1);
    curReq = "R5";
    cyc(0, '0, 0);
    queueNotEmpty = 1'b1;
    cyc(0, '0, 0);
    chk("R5", "resume without go", int'(startCell), 1);

    // R7: go inside a cell
    curReq = "R7";
    cyc(1, '0, 0);
    chk("R7", "no extra start on go", int'(startCell), 0);
    chk("R7", "armed on go", int'(injArmed), 1);
    cyc(0, '0, 0);
    chk("R7", "still in flight", int'(startCell), 0);
    cyc(0, '0, 1);
    chk("R7", "start after done", int'(startCell), 1);

    // R8 / R6: NACK on source 1 inside a cell
    curReq = "R8";
    cyc(0, 2'b10, 0);
    chk("R6", "disarm on nack", int'(injArmed), 0);
    chk("R8", "no start on nack", int'(startCell), 0);
    cyc(0, '0, 1);
    chk("R8", "no start after nacked cell", int'(startCell), 0);
    curReq = "R6";
    for (int i = 0; i < 4; i++) begin
      cyc(0, '0, 0);
      chk("R6", "stays stopped", int'(startCell), 0);
    end

    // R9: go and NACK (source 0) together
    curReq = "R9";
    cyc(1, 2'b01, 0);
    chk("R9", "nack wins", int'(injArmed), 0);
    chk("R9", "no start", int'(startCell), 0);
    curReq = "R6";
    cyc(1, '0, 0);
    chk("R6", "rearm start", int'(startCell), 1);
    cyc(0, '0, 1);
    chk("R6", "continues after rearm", int'(startCell), 1);
    cyc(0, 2'b01, 1);
    chk("R6", "nack source 0 disarms", int'(injArmed), 0);
    chk("R6", "nack blocks restart", int'(startCell), 0);
    repeat (3) cyc(0, '0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule